// File: doc/BRIEF.md
# Warp Lane Shuffle Network

This block moves data words between the lanes of a 32-lane group in one operation. Every lane presents one word. A single control set applies to all lanes: an addressing mode, one lane operand, a sub-group width and a participation mask. From these the block works out a source lane for every lane and hands each lane the word held by that source. It is used beside a lane-parallel datapath to carry out broadcasts, neighbour shifts and butterfly exchanges, such as those found in tree reductions.

The lane group can be split into equal power-of-two sub-groups. Each sub-group behaves as an independent unit whose local lane numbers start at zero. Each mode has its own rule for sources that fall outside the caller's sub-group. A width that is not a power of two, or that is larger than the lane count, is rejected. A participating lane whose source does not participate is also rejected. In both cases an error flag is raised and every lane gets back its own word. The result is registered and is presented one clock after the request.

Top module: `lane_xchg_top`

## Requirements
- R1: Indexed mode (req_mode = 0): a participating lane receives the word of lane base + (req_param mod W). Here W is req_width and base is the first lane of the caller's sub-group.
- R2: Sub-groups are the aligned blocks of W consecutive lanes. In every mode, no source lies outside the caller's sub-group, with one exception: mode 3 may reach earlier sub-groups.
- R3: Shift-up mode (req_mode = 1): a lane whose local index is at least req_param receives the word of its own lane minus req_param. All other lanes keep their own word.
- R4: Shift-down mode (req_mode = 2): a lane whose local index plus req_param is below W receives the word of its own lane plus req_param. All other lanes keep their own word.
- R5: Butterfly mode (req_mode = 3): the source is the caller's lane XOR req_param. If that source lies in a later sub-group, the caller keeps its own word.
- R6: A lane whose req_mask bit (bit i for lane i) is clear receives its own word.
- R7: If req_width is not one of 1, 2, 4, 8, 16 or 32, rsp_err is 1 and every lane receives its own word.
- R8: If any participating lane's source lane has a clear mask bit, rsp_err is 1 and every lane receives its own word.
- R9: rsp_valid is req_valid delayed by exactly one clock. Results of back-to-back requests follow one another on consecutive cycles.
- R10: After reset, and whenever rsp_valid is 0, rsp_err is 0. Reset also clears rsp_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | 0 indexed, 1 shift-up, 2 shift-down, 3 butterfly |
| req_param | input | 5 | Source index, shift distance or XOR mask |
| req_width | input | 6 | Sub-group width as a plain number |
| req_mask | input | 32 | Participation mask, bit i for lane i |
| req_data | input | 1024 | Lane words, lane i at bits i*32 upward |
| rsp_valid | output | 1 | Result present |
| rsp_err | output | 1 | Request rejected; outputs equal inputs |
| rsp_data | output | 1024 | Lane results, same packing as req_data |

## Verification
The only state in this block is the output register. A wrong source calculation therefore shows up as a misplaced word in rsp_data on the cycle right after the request. A missed rejection shows up on that same cycle as rsp_err staying low while words still move between lanes. Random requests across all four modes, many widths and partial masks are compared word by word with a reference model in the bench. Directed cases target the sub-group edges, the later-group rule of the butterfly mode and the widths that must be rejected.

// File: rtl/lane_xchg_pkg.sv
package lane_xchg_pkg;

   typedef enum logic [1:0] {
      XM_INDEX = 2'd0,
      XM_UP    = 2'd1,
      XM_DOWN  = 2'd2,
      XM_BFLY  = 2'd3
   } xchg_mode_e;

   // legal sub-group width: nonzero power of two not above the lane count
   function automatic logic width_ok(input int unsigned w, input int unsigned n);
      return (w != 0) && ((w & (w - 1)) == 0) && (w <= n);
   endfunction

endpackage

// File: rtl/lane_xchg_srcgen.sv
module lane_xchg_srcgen #(
   parameter int LANES = 32,
   parameter int LANE  = 0,
   localparam int LIDW = $clog2(LANES)
) (
   input  lane_xchg_pkg::xchg_mode_e mode_i,
   input  logic [LIDW-1:0]           param_i,
   input  logic [LIDW-1:0]           wmask_i,
   output logic [LIDW-1:0]           src_o
);
   localparam logic [LIDW-1:0] LID = LIDW'(LANE);

   logic [LIDW-1:0] base, loc, flip;
   logic [LIDW:0]   reach;

   always_comb begin
      base  = LID & ~wmask_i;
      loc   = LID & wmask_i;
      flip  = LID ^ param_i;
      reach = {1'b0, loc} + {1'b0, param_i};
      unique case (mode_i)
         lane_xchg_pkg::XM_INDEX: src_o = base | (param_i & wmask_i);
         lane_xchg_pkg::XM_UP:    src_o = (loc >= param_i) ? (LID - param_i) : LID;
         lane_xchg_pkg::XM_DOWN:  src_o = (reach <= {1'b0, wmask_i}) ? (LID + param_i) : LID;
         default:                 src_o = ((flip & ~wmask_i) > base) ? LID : flip;
      endcase
   end
endmodule

// File: rtl/lane_xchg_xbar.sv
module lane_xchg_xbar #(
   parameter int LANES = 32,
   parameter int DW    = 32,
   localparam int LIDW = $clog2(LANES)
) (
   input  logic [LANES*DW-1:0] data_i,
   input  logic [LIDW-1:0]     src_i  [LANES],
   output logic [DW-1:0]       data_o [LANES]
);
   logic [DW-1:0] words [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign words[g] = data_i[g*DW +: DW];
   end

   for (genvar g = 0; g < LANES; g++) begin : g_pick
      assign data_o[g] = words[src_i[g]];
   end
endmodule

// File: rtl/lane_xchg_top.sv
module lane_xchg_top #(
   parameter int LANES = 32,
   parameter int DW    = 32,
   localparam int LIDW = $clog2(LANES),
   localparam int WW   = LIDW + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_mode,
   input  logic [LIDW-1:0]     req_param,
   input  logic [WW-1:0]       req_width,
   input  logic [LANES-1:0]    req_mask,
   input  logic [LANES*DW-1:0] req_data,
   output logic                rsp_valid,
   output logic                rsp_err,
   output logic [LANES*DW-1:0] rsp_data
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   lane_xchg_pkg::xchg_mode_e mode;
   logic                legal;
   logic [LIDW-1:0]     wmask;
   logic [LIDW-1:0]     src  [LANES];
   logic [DW-1:0]       gath [LANES];
   logic [LANES-1:0]    miss;
   logic                err_c;
   logic [LANES*DW-1:0] nxt;

   assign mode  = lane_xchg_pkg::xchg_mode_e'(req_mode);
   assign legal = lane_xchg_pkg::width_ok(32'(req_width), LANES);
   assign wmask = LIDW'(req_width - WW'(1));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      lane_xchg_srcgen #(.LANES(LANES), .LANE(g)) u_src (
         .mode_i  (mode),
         .param_i (req_param),
         .wmask_i (wmask),
         .src_o   (src[g])
      );
      assign miss[g] = req_mask[g] & ~req_mask[src[g]];
   end

   lane_xchg_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
      .data_i (req_data),
      .src_i  (src),
      .data_o (gath)
   );

   assign err_c = ~legal | (|miss);

   for (genvar g = 0; g < LANES; g++) begin : g_sel
      assign nxt[g*DW +: DW] = (err_c | ~req_mask[g]) ? req_data[g*DW +: DW] : gath[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid & err_c;
         if (req_valid) rsp_data <= nxt;
      end
   end
endmodule

// File: rtl/lane_xchg_chk.sv
module lane_xchg_chk #(
   parameter int LANES = 32,
   parameter int DW    = 32,
   localparam int LIDW = $clog2(LANES),
   localparam int WW   = LIDW + 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [WW-1:0]       req_width,
   input logic                req_mask0,
   input logic [LANES*DW-1:0] req_data,
   input logic                rsp_valid,
   input logic                rsp_err,
   input logic [LANES*DW-1:0] rsp_data
);
   // R9: response flag trails the request flag by one clock
   a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R7: a width that is not a power of two up to LANES is rejected
   a_r7_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !($countones(req_width) == 1 && req_width <= WW'(LANES)))
      |=> (rsp_valid && rsp_err));

   // R7/R8: a rejected request returns every word unchanged
   a_r8_err_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_err || rsp_data == $past(req_data)));

   // R6: a non-participating lane keeps its word
   a_r6_lane0_own: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_mask0) |=> (rsp_data[DW-1:0] == $past(req_data[DW-1:0])));

   // R10: no error without a response
   a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_err);
endmodule

bind lane_xchg_top lane_xchg_chk #(.LANES(LANES), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_width (req_width),
   .req_mask0 (req_mask[0]),
   .req_data  (req_data),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_data  (rsp_data)
);

// File: tb/tb_lane_xchg_top.sv
module tb_lane_xchg_top;
   localparam int LANES = 32;
   localparam int DW    = 32;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic [1:0]          req_mode = '0;
   logic [4:0]          req_param = '0;
   logic [5:0]          req_width = 6'd32;
   logic [LANES-1:0]    req_mask = '1;
   logic [LANES*DW-1:0] req_data = '0;
   logic                rsp_valid, rsp_err;
   logic [LANES*DW-1:0] rsp_data;

   int checks = 0;
   int bad = 0;

   logic                e_valid = 1'b0;
   logic                e_err = 1'b0;
   logic [LANES*DW-1:0] e_data = '0;
   string               e_tag = "R9";

   lane_xchg_top #(.LANES(LANES), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_param(req_param), .req_width(req_width), .req_mask(req_mask),
      .req_data(req_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_data(rsp_data)
   );

   always #4 clk = ~clk;

   initial begin
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   function automatic int src_of(int i, int mode, int p, int w);
      int base = (i / w) * w;
      int loc  = i % w;
      int t;
      case (mode)
         0: return base + (p % w);
         1: return (loc >= p) ? i - p : i;
         2: return (loc + p < w) ? i + p : i;
         default: begin
            t = i ^ p;
            return (t >= base + w) ? i : t;
         end
      endcase
   endfunction

   task automatic chk1(string tag, logic [LANES*DW-1:0] act, logic [LANES*DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_prev();
      if (e_valid) begin
         chk1({e_tag, "/R9 valid"}, {1023'd0, rsp_valid}, {1023'd0, 1'b1});
         chk1({e_tag, " err"}, {1023'd0, rsp_err}, {1023'd0, e_err});
         chk1({e_tag, " data"}, rsp_data, e_data);
      end else begin
         chk1("R9/R10 idle valid", {1023'd0, rsp_valid}, 1024'd0);
         chk1("R10 idle err", {1023'd0, rsp_err}, 1024'd0);
      end
   endtask

   task automatic issue(bit v, int mode, int p, int w, logic [LANES-1:0] m,
                        logic [LANES*DW-1:0] d, string tag);
      logic err;
      int s;
      @(negedge clk);
      check_prev();
      req_valid = v;
      req_mode  = 2'(mode);
      req_param = 5'(p);
      req_width = 6'(w);
      req_mask  = m;
      req_data  = d;
      err = !(w == 1 || w == 2 || w == 4 || w == 8 || w == 16 || w == 32);
      if (!err) begin
         for (int i = 0; i < LANES; i++) begin
            s = src_of(i, mode, p, w);
            if (m[i] && !m[s]) err = 1'b1;
         end
      end
      for (int i = 0; i < LANES; i++) begin
         s = (err || !m[i]) ? i : src_of(i, mode, p, w);
         e_data[i*DW +: DW] = d[s*DW +: DW];
      end
      e_valid = v;
      e_err   = err;
      e_tag   = tag;
   endtask

   function automatic logic [LANES*DW-1:0] rand_data();
      logic [LANES*DW-1:0] d;
      for (int i = 0; i < LANES; i++) d[i*DW +: DW] = $urandom;
      return d;
   endfunction

   initial begin
      int ws [6] = '{1, 2, 4, 8, 16, 32};
      int w, mode;
      logic [LANES-1:0] m;
      void'($urandom(32'd20240611));
      #20;
      @(negedge clk);
      // R10: reset state
      chk1("R10 reset valid", {1023'd0, rsp_valid}, 1024'd0);
      chk1("R10 reset err", {1023'd0, rsp_err}, 1024'd0);
      chk1("R10 reset data", rsp_data, 1024'd0);
      rst_n = 1'b1;

      // directed corners
      issue(1, 0, 11, 8, '1, rand_data(), "R1 index modulo");
      issue(1, 0, 31, 32, '1, rand_data(), "R1 broadcast");
      issue(1, 0, 2, 4, '1, rand_data(), "R2 index groups");
      issue(1, 1, 3, 8, '1, rand_data(), "R3 up");
      issue(1, 1, 9, 8, '1, rand_data(), "R3 up beyond width");
      issue(1, 2, 5, 16, '1, rand_data(), "R4 down");
      issue(1, 2, 1, 1, '1, rand_data(), "R4 width one");
      issue(1, 3, 12, 8, '1, rand_data(), "R5 xor later group");
      issue(1, 3, 31, 32, '1, rand_data(), "R5 xor full");
      issue(1, 3, 4, 4, '1, rand_data(), "R5 xor earlier group");
      issue(0, 0, 0, 32, '1, rand_data(), "R9 gap");
      issue(1, 2, 1, 16, 32'hFFFF_0000, rand_data(), "R6 partial mask");
      issue(1, 1, 1, 32, 32'hFFFF_0000, rand_data(), "R8 source off");
      issue(1, 0, 0, 3, '1, rand_data(), "R7 width three");
      issue(1, 0, 0, 0, '1, rand_data(), "R7 width zero");
      issue(1, 0, 0, 33, '1, rand_data(), "R7 width 33");
      issue(1, 0, 0, 48, '1, rand_data(), "R7 width 48");

      // constrained random
      for (int n = 0; n < 600; n++) begin
         mode = int'($urandom_range(0, 3));
         w = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 63)) : ws[$urandom_range(0, 5)];
         case ($urandom_range(0, 3))
            0: m = $urandom;
            1: m = ~(32'd1 << $urandom_range(0, 31));
            default: m = '1;
         endcase
         issue($urandom_range(0, 4) != 0, mode, int'($urandom_range(0, 31)), w, m,
               rand_data(),
               (mode == 0) ? "R1/R2 rand index" :
               (mode == 1) ? "R3 rand up" :
               (mode == 2) ? "R4 rand down" : "R5 rand xor");
      end
      issue(0, 0, 0, 32, '1, '0, "R9 flush");
      @(negedge clk);
      check_prev();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule